// File: doc/BRIEF.md
# Storage Port Interrupt Status Register

This block holds the per-port interrupt status word of a serial storage host controller. Hardware event strobes from the frame receiver, the data mover and the link layer are caught in sticky status bits. Software clears most of these bits by writing a one to them. Three bits are not sticky: they follow flags kept in a companion diagnostic register, and they clear only when that register is cleared. One of these three, the unknown-frame indication, sets only once the frame has been posted to memory. It is held at zero whenever its diagnostic flag is clear, so the two never disagree for long.

Reads are served straight from the `status_o` word. A write carries a full 32-bit data word and a write strobe. An aggregate interrupt request is formed from the status word and a per-bit enable mask. Frame parsing, DMA and the full diagnostic register sit outside the block and arrive as strobes and flag levels.

Top module: `port_irq_status`

## Requirements
- R1: After a synchronous active-low reset every status bit is 0 and `irq_o` is 0 while no flag input is set.
- R2: The sticky event bits 0 (register frame), 1 (PIO setup), 2 (DMA setup), 3 (set-device-bits), 5 (descriptor done), 23 (port multiplier mismatch), 24 (overflow), 26 (interface non-fatal), 27 (interface fatal), 28 (host bus data), 29 (host bus fatal) and 30 (task file error) read 1 from the cycle after their strobe and hold until cleared.
- R3: A write with `wr_en_i` high clears, from the next cycle, each sticky bit whose data bit is 1. Data bits of 0 leave the matching status bits unchanged.
- R4: When a strobe and a write-one clear reach the same sticky bit in the same cycle, the bit reads 1 afterwards.
- R5: Bit 30 sets only in a cycle where both `tf_upd_i` and `tf_err_i` are high. A status update without the error flag does not set it.
- R6: Bit 7 sets on `evt_mps_i` only while both `cap_ctl_mps_i` and `cap_port_mps_i` are 1. In any cycle where either capability is 0, bit 7 reads 0 from the next cycle.
- R7: Bit 22 equals `diag_phy_chg_i` delayed by one cycle. Writes do not affect it.
- R8: Bit 6 equals `diag_conn_chg_i` delayed by one cycle. Writes do not affect it.
- R9: Bit 4 sets in the cycle after `unk_posted_i` while `diag_unk_frm_i` is 1. It reads 0 from the cycle after `diag_unk_frm_i` is 0, and a post seen while that flag is 0 is dropped. Writes do not affect it.
- R10: Bits 31, 25 and 21:8 always read 0, including after writes of all ones.
- R11: `irq_o` is 1 exactly when some bit of `status_o & irq_mask_i` is 1. It responds to the mask in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_d2h_i | input | 1 | Register frame with interrupt flag stored (bit 0) |
| evt_pio_i | input | 1 | PIO setup frame handled, even on a data error (bit 1) |
| evt_dma_i | input | 1 | DMA setup frame stored (bit 2) |
| evt_sdb_i | input | 1 | Set-device-bits frame stored (bit 3) |
| evt_desc_i | input | 1 | Descriptor with interrupt flag finished (bit 5) |
| evt_mps_i | input | 1 | Presence switch opened or closed (bit 7) |
| evt_pmerr_i | input | 1 | Frame from an unexpected port multiplier port (bit 23) |
| evt_ovf_i | input | 1 | More bytes received than described (bit 24) |
| evt_ifnf_i | input | 1 | Recoverable link interface error (bit 26) |
| evt_iff_i | input | 1 | Link interface error that stopped the transfer (bit 27) |
| evt_hbdata_i | input | 1 | Uncorrectable host memory data error (bit 28) |
| evt_hbfatal_i | input | 1 | Unrecoverable host bus error (bit 29) |
| tf_upd_i | input | 1 | Device updated the task file status |
| tf_err_i | input | 1 | Error bit of the received status field |
| unk_posted_i | input | 1 | Unknown frame has been posted to memory |
| diag_phy_chg_i | input | 1 | Diagnostic flag: PHY ready changed |
| diag_conn_chg_i | input | 1 | Diagnostic flag: connection changed |
| diag_unk_frm_i | input | 1 | Diagnostic flag: unknown frame seen |
| cap_ctl_mps_i | input | 1 | Controller supports a presence switch |
| cap_port_mps_i | input | 1 | Port has a presence switch |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 32 | Register write data, one clears a sticky bit |
| irq_mask_i | input | 32 | Per-bit interrupt enable |
| status_o | output | 32 | Status word (read data) |
| irq_o | output | 1 | Aggregate interrupt request |

## Verification
The hardest case to reach from the ports is an event strobe landing on the same bit, in the same cycle, as a write-one clear. Purely random writes rarely produce it for one chosen bit, so the bench drives this collision directly and also biases random writes toward all-ones words. A second hard case is the unknown-frame bit, which must stay in step with its diagnostic flag. For it, directed steps post a frame while the flag is clear, and then drop the flag while the bit is set. The random phase toggles the flag and the post pulse on their own so that both orders keep recurring.

// File: rtl/pirq_pkg.sv
// Package: shared constants and types of the port interrupt status register.
// Assumes a 32-bit status word; bit positions are fixed because software
// decodes them.
package pirq_pkg;
    localparam int REG_W     = 32;
    localparam int N_STICKY  = 13;

    // Positions of the non-sticky bits.
    localparam int BIT_UNK   = 4;
    localparam int BIT_CONN  = 6;
    localparam int BIT_PHY   = 22;

    // Index of special entries inside the sticky bank.
    localparam int SIDX_MPS  = 5;
    localparam int SIDX_TFE  = 12;

    // Register bit position of each sticky bank entry.
    localparam int STICKY_POS [N_STICKY] =
        '{0, 1, 2, 3, 5, 7, 23, 24, 26, 27, 28, 29, 30};

    typedef logic [REG_W-1:0] word_t;
endpackage

// File: rtl/pirq_sticky_bank.sv
// Module: bank of write-one-to-clear sticky bits.
// Each bit sets on its strobe, clears on its clear request, and a set wins
// over a clear in the same cycle. A kill input forces a bit to zero.
// Assumes set, clear and kill are synchronous to clk.
module pirq_sticky_bank #(
    parameter int N = 13
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    input  logic [N-1:0] kill_i,
    output logic [N-1:0] q_o
);
    logic [N-1:0] q_r;
    logic [N-1:0] q_nx;

    // Per-bit next state: kill dominates, then set, then clear.
    generate
        for (genvar i = 0; i < N; i++) begin : g_nx
            assign q_nx[i] = kill_i[i] ? 1'b0 : (set_i[i] | (q_r[i] & ~clr_i[i]));
        end
    endgenerate

    // Register the bank state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_r <= '0;
        end else begin
            q_r <= q_nx;
        end
    end

    assign q_o = q_r;
endmodule

// File: rtl/pirq_diag_mirror.sv
// Module: registered copies of the companion diagnostic flags.
// The PHY-change and connect-change bits follow their flags one cycle late.
// The unknown-frame bit sets on a post pulse but only while its flag is set,
// and is cleared whenever the flag is clear, so the two stay in step.
// Assumes all inputs are synchronous to clk.
module pirq_diag_mirror (
    input  logic clk,
    input  logic rst_n,
    input  logic diag_phy_i,
    input  logic diag_conn_i,
    input  logic diag_unk_i,
    input  logic unk_posted_i,
    output logic phy_chg_o,
    output logic conn_chg_o,
    output logic unk_o
);
    logic phy_r;
    logic conn_r;
    logic unk_r;

    // Track the diagnostic flags and the posted unknown-frame indication.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phy_r  <= 1'b0;
            conn_r <= 1'b0;
            unk_r  <= 1'b0;
        end else begin
            phy_r  <= diag_phy_i;
            conn_r <= diag_conn_i;
            unk_r  <= (unk_r | unk_posted_i) & diag_unk_i;
        end
    end

    assign phy_chg_o  = phy_r;
    assign conn_chg_o = conn_r;
    assign unk_o      = unk_r;
endmodule

// File: rtl/pirq_irq_agg.sv
// Module: aggregate interrupt request.
// ORs the masked status word. Assumes the status word comes from registers,
// so only the mask input adds a combinational path to the output.
module pirq_irq_agg #(
    parameter int W = 32
) (
    input  logic [W-1:0] status_i,
    input  logic [W-1:0] mask_i,
    output logic         irq_o
);
    logic [W-1:0] hit;

    // Per-bit enable gating.
    generate
        for (genvar i = 0; i < W; i++) begin : g_hit
            assign hit[i] = status_i[i] & mask_i[i];
        end
    endgenerate

    assign irq_o = |hit;
endmodule

// File: rtl/port_irq_status.sv
// Module: per-port interrupt status register of a serial storage host.
// Collects event strobes into sticky write-one-to-clear bits. It mirrors three
// companion diagnostic flags into read-only bits and drives a masked
// interrupt request. Reserved and unsupported bits read 0.
// Assumes all inputs are synchronous to clk and reset is synchronous,
// active low.
module port_irq_status
    import pirq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evt_d2h_i,
    input  logic              evt_pio_i,
    input  logic              evt_dma_i,
    input  logic              evt_sdb_i,
    input  logic              evt_desc_i,
    input  logic              evt_mps_i,
    input  logic              evt_pmerr_i,
    input  logic              evt_ovf_i,
    input  logic              evt_ifnf_i,
    input  logic              evt_iff_i,
    input  logic              evt_hbdata_i,
    input  logic              evt_hbfatal_i,
    input  logic              tf_upd_i,
    input  logic              tf_err_i,
    input  logic              unk_posted_i,
    input  logic              diag_phy_chg_i,
    input  logic              diag_conn_chg_i,
    input  logic              diag_unk_frm_i,
    input  logic              cap_ctl_mps_i,
    input  logic              cap_port_mps_i,
    input  logic              wr_en_i,
    input  logic [REG_W-1:0]  wr_data_i,
    input  logic [REG_W-1:0]  irq_mask_i,
    output logic [REG_W-1:0]  status_o,
    output logic              irq_o
);
    logic [N_STICKY-1:0] set_vec;
    logic [N_STICKY-1:0] clr_vec;
    logic [N_STICKY-1:0] kill_vec;
    logic [N_STICKY-1:0] sticky_q;
    logic                mps_ok;
    logic                tfe_set;
    logic                mps_set;
    logic                phy_q;
    logic                conn_q;
    logic                unk_q;
    word_t               status_w;
    word_t               sticky_mask;
    logic                wr_unused;

    // Event qualification.
    assign mps_ok  = cap_ctl_mps_i & cap_port_mps_i;
    assign mps_set = evt_mps_i & mps_ok;
    assign tfe_set = tf_upd_i & tf_err_i;

    // Strobes in sticky-bank order (index 0 first).
    assign set_vec = {tfe_set, evt_hbfatal_i, evt_hbdata_i, evt_iff_i,
                      evt_ifnf_i, evt_ovf_i, evt_pmerr_i, mps_set,
                      evt_desc_i, evt_sdb_i, evt_dma_i, evt_pio_i, evt_d2h_i};

    // Map write data onto bank clear requests, and gate the switch bit.
    generate
        for (genvar i = 0; i < N_STICKY; i++) begin : g_map
            assign clr_vec[i]  = wr_en_i & wr_data_i[STICKY_POS[i]];
            if (i == SIDX_MPS) begin : g_kill
                assign kill_vec[i] = ~mps_ok;
            end else begin : g_keep
                assign kill_vec[i] = 1'b0;
            end
        end
    endgenerate

    // Mask of writable positions, used only to mark ignored write data.
    always_comb begin
        sticky_mask = '0;
        for (int i = 0; i < N_STICKY; i++) begin
            sticky_mask[STICKY_POS[i]] = 1'b1;
        end
    end
    assign wr_unused = ^(wr_data_i & ~sticky_mask);

    pirq_sticky_bank #(
        .N (N_STICKY)
    ) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (set_vec),
        .clr_i  (clr_vec),
        .kill_i (kill_vec),
        .q_o    (sticky_q)
    );

    pirq_diag_mirror u_mirror (
        .clk          (clk),
        .rst_n        (rst_n),
        .diag_phy_i   (diag_phy_chg_i),
        .diag_conn_i  (diag_conn_chg_i),
        .diag_unk_i   (diag_unk_frm_i),
        .unk_posted_i (unk_posted_i),
        .phy_chg_o    (phy_q),
        .conn_chg_o   (conn_q),
        .unk_o        (unk_q)
    );

    // Assemble the status word; reserved and unsupported bits stay 0.
    always_comb begin
        status_w = '0;
        for (int i = 0; i < N_STICKY; i++) begin
            status_w[STICKY_POS[i]] = sticky_q[i];
        end
        status_w[BIT_PHY]  = phy_q;
        status_w[BIT_CONN] = conn_q;
        status_w[BIT_UNK]  = unk_q;
    end

    pirq_irq_agg #(
        .W (REG_W)
    ) u_irq (
        .status_i (status_w),
        .mask_i   (irq_mask_i),
        .irq_o    (irq_o)
    );

    assign status_o = status_w;
endmodule

// File: rtl/pirq_checker.sv
// Module: assertion checker for port_irq_status, attached by bind.
// Assumes synchronous active-low reset; all properties are disabled in reset.
module pirq_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        evt_d2h_i,
    input logic        evt_ovf_i,
    input logic        tf_upd_i,
    input logic        tf_err_i,
    input logic        diag_phy_chg_i,
    input logic        diag_conn_chg_i,
    input logic        diag_unk_frm_i,
    input logic        cap_ctl_mps_i,
    input logic        cap_port_mps_i,
    input logic        wr_en_i,
    input logic        wr_d0,
    input logic        wr_d24,
    input logic [31:0] irq_mask_i,
    input logic [31:0] status_o,
    input logic        irq_o
);
    p_sticky_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o[0] && !(wr_en_i && wr_d0)) |=> status_o[0]);

    p_w1c_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_d24 && !evt_ovf_i) |=> !status_o[24]);

    p_set_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
        evt_d2h_i |=> status_o[0]);

    p_tfe_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!(tf_upd_i && tf_err_i) && !status_o[30]) |=> !status_o[30]);

    p_mps_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(cap_ctl_mps_i && cap_port_mps_i) |=> !status_o[7]);

    p_phy_mirror_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (status_o[22] == $past(diag_phy_chg_i)));

    p_conn_mirror_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (status_o[6] == $past(diag_conn_chg_i)));

    p_unk_sync_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !diag_unk_frm_i |=> !status_o[4]);

    p_irq_raise_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ((status_o & irq_mask_i) != 32'd0) |-> irq_o);
endmodule

bind port_irq_status pirq_checker u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .evt_d2h_i       (evt_d2h_i),
    .evt_ovf_i       (evt_ovf_i),
    .tf_upd_i        (tf_upd_i),
    .tf_err_i        (tf_err_i),
    .diag_phy_chg_i  (diag_phy_chg_i),
    .diag_conn_chg_i (diag_conn_chg_i),
    .diag_unk_frm_i  (diag_unk_frm_i),
    .cap_ctl_mps_i   (cap_ctl_mps_i),
    .cap_port_mps_i  (cap_port_mps_i),
    .wr_en_i         (wr_en_i),
    .wr_d0           (wr_data_i[0]),
    .wr_d24          (wr_data_i[24]),
    .irq_mask_i      (irq_mask_i),
    .status_o        (status_o),
    .irq_o           (irq_o)
);

// File: tb/port_irq_status_bench.sv
// Bench: directed corner cases plus seeded random stimulus, checked against
// a bench-side model of the status word built from the requirements.
module port_irq_status_bench;
    timeunit 1ns;
    timeprecision 100ps;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] ev = '0;     // 0 d2h,1 pio,2 dma,3 sdb,4 desc,5 mps,6 pmerr,7 ovf,8 ifnf,9 iff,10 hbdata,11 hbfatal
    logic        upd = 1'b0, err = 1'b0, posted = 1'b0;
    logic        dphy = 1'b0, dconn = 1'b0, dunk = 1'b0;
    logic        capc = 1'b0, capp = 1'b0;
    logic        we = 1'b0;
    logic [31:0] wd = '0, msk = '0;
    logic [31:0] status;
    logic        irq;
    logic [31:0] exp_q = '0;
    int          total = 0, bad = 0;
    int          seed_val;

    localparam int EPOS [12] = '{0, 1, 2, 3, 5, 7, 23, 24, 26, 27, 28, 29};
    localparam logic [31:0] STICKY_M = 32'h3D80_002F;  // 0,1,2,3,5,23,24,26..29
    localparam logic [31:0] RSVD_M   = 32'h8200_FF00 | 32'h003F_0000;

    always #2.5 clk = ~clk;

    port_irq_status u_port_irq_status (
        .clk(clk), .rst_n(rst_n),
        .evt_d2h_i(ev[0]), .evt_pio_i(ev[1]), .evt_dma_i(ev[2]), .evt_sdb_i(ev[3]),
        .evt_desc_i(ev[4]), .evt_mps_i(ev[5]), .evt_pmerr_i(ev[6]), .evt_ovf_i(ev[7]),
        .evt_ifnf_i(ev[8]), .evt_iff_i(ev[9]), .evt_hbdata_i(ev[10]), .evt_hbfatal_i(ev[11]),
        .tf_upd_i(upd), .tf_err_i(err), .unk_posted_i(posted),
        .diag_phy_chg_i(dphy), .diag_conn_chg_i(dconn), .diag_unk_frm_i(dunk),
        .cap_ctl_mps_i(capc), .cap_port_mps_i(capp),
        .wr_en_i(we), .wr_data_i(wd), .irq_mask_i(msk),
        .status_o(status), .irq_o(irq)
    );

    // Expected next status word from the current expected word and inputs.
    function automatic logic [31:0] model_next();
        logic [31:0] clr;
        logic [31:0] n;
        clr = we ? wd : 32'd0;
        n = '0;
        for (int i = 0; i < 12; i++) begin
            n[EPOS[i]] = ev[i] | (exp_q[EPOS[i]] & ~clr[EPOS[i]]);
        end
        n[30] = (upd & err) | (exp_q[30] & ~clr[30]);
        if (!(capc && capp)) n[7] = 1'b0;
        n[22] = dphy;
        n[6]  = dconn;
        n[4]  = (exp_q[4] | posted) & dunk;
        return n;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // Compare every field group against the model.
    task automatic check_all();
        chk("R2/R3/R4 sticky event bits", status & STICKY_M, exp_q & STICKY_M);
        chk("R5 task file bit30", {31'd0, status[30]}, {31'd0, exp_q[30]});
        chk("R6 presence bit7", {31'd0, status[7]}, {31'd0, exp_q[7]});
        chk("R7 phy change bit22", {31'd0, status[22]}, {31'd0, exp_q[22]});
        chk("R8 connect change bit6", {31'd0, status[6]}, {31'd0, exp_q[6]});
        chk("R9 unknown frame bit4", {31'd0, status[4]}, {31'd0, exp_q[4]});
        chk("R10 reserved bits", status & RSVD_M, 32'd0);
        chk("R11 irq", {31'd0, irq}, {31'd0, |(exp_q & msk)});
    endtask

    // One clock: inputs already driven at a falling edge.
    task automatic tick();
        logic [31:0] nx;
        nx = model_next();
        @(posedge clk);
        exp_q = nx;
        @(negedge clk);
        check_all();
        ev = '0; upd = 1'b0; err = 1'b0; posted = 1'b0; we = 1'b0; wd = '0;
    endtask

    initial begin
        #(5.0 * 200000);
        bad++;
        $display("FAIL watchdog expired act=%0d exp=%0d", 1, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        seed_val = $urandom(32'd20241);
        msk = 32'hFFFF_FFFF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk("R1 status after reset", status, 32'd0);
        chk("R1 irq after reset", {31'd0, irq}, 32'd0);

        // R4: strobe and clear on bit 0 in the same cycle
        ev[0] = 1'b1; we = 1'b1; wd = 32'h0000_0001; tick();
        chk("R4 set wins over clear", {31'd0, status[0]}, 32'd1);
        // R3: zero write keeps, one write clears
        ev[7] = 1'b1; tick();
        we = 1'b1; wd = 32'h0000_0000; tick();
        chk("R3 zero write keeps bit24", {31'd0, status[24]}, 32'd1);
        we = 1'b1; wd = 32'h0100_0000; tick();
        chk("R3 one write clears bit24", {31'd0, status[24]}, 32'd0);
        chk("R2 bit0 still held", {31'd0, status[0]}, 32'd1);

        // R5: update without error, then with error
        upd = 1'b1; tick();
        chk("R5 no error no set", {31'd0, status[30]}, 32'd0);
        upd = 1'b1; err = 1'b1; tick();
        chk("R5 error sets bit30", {31'd0, status[30]}, 32'd1);

        // R6: capability gating of the presence switch
        capc = 1'b1; capp = 1'b0; ev[5] = 1'b1; tick();
        chk("R6 one cap blocks", {31'd0, status[7]}, 32'd0);
        capp = 1'b1; ev[5] = 1'b1; tick();
        chk("R6 both caps set", {31'd0, status[7]}, 32'd1);
        capc = 1'b0; tick();
        chk("R6 cap drop clears", {31'd0, status[7]}, 32'd0);

        // R7/R8: mirrors ignore writes
        dphy = 1'b1; dconn = 1'b1; tick();
        we = 1'b1; wd = 32'h0040_0040; tick();
        chk("R7 write ignored bit22", {31'd0, status[22]}, 32'd1);
        chk("R8 write ignored bit6", {31'd0, status[6]}, 32'd1);
        dphy = 1'b0; dconn = 1'b0; tick();

        // R9: post with flag clear is dropped; set, write, then flag drop
        posted = 1'b1; tick();
        chk("R9 post without flag dropped", {31'd0, status[4]}, 32'd0);
        dunk = 1'b1; tick();
        posted = 1'b1; tick();
        chk("R9 post with flag sets", {31'd0, status[4]}, 32'd1);
        we = 1'b1; wd = 32'h0000_0010; tick();
        chk("R9 write ignored bit4", {31'd0, status[4]}, 32'd1);
        dunk = 1'b0; tick();
        chk("R9 flag clear clears bit4", {31'd0, status[4]}, 32'd0);

        // R10: all-ones write leaves reserved bits at 0
        we = 1'b1; wd = 32'hFFFF_FFFF; tick();
        chk("R10 reserved after ones write", status & RSVD_M, 32'd0);

        // R11: mask responds in the same cycle
        ev[2] = 1'b1; msk = 32'd0; tick();
        chk("R11 masked off", {31'd0, irq}, 32'd0);
        msk = 32'h0000_0004; #1;
        chk("R11 mask enables", {31'd0, irq}, 32'd1);

        // Random phase
        for (int c = 0; c < 4000; c++) begin
            ev     = 12'($urandom & $urandom & $urandom);
            upd    = ($urandom % 4) == 0;
            err    = $urandom % 2;
            posted = ($urandom % 6) == 0;
            if (($urandom % 8) == 0) dphy  = ~dphy;
            if (($urandom % 8) == 0) dconn = ~dconn;
            if (($urandom % 7) == 0) dunk  = ~dunk;
            if (($urandom % 16) == 0) capc = ~capc;
            if (($urandom % 16) == 0) capp = ~capp;
            we  = ($urandom % 3) == 0;
            wd  = (($urandom % 4) == 0) ? 32'hFFFF_FFFF : $urandom;
            if (($urandom % 5) == 0) msk = $urandom & $urandom;
            tick();
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule